// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Bank

The bank holds seventeen 128-bit one-time-programmable registers. A 16-bit command port reaches them one word at a time. Cells behave like flash cells that cannot be erased. A program command can only clear data bits, so the stored word becomes the old word ANDed with the written word. Two lock words decide which segments may still change.

Register 0 has two halves. Its lower half is a factory segment and is locked from reset. Its upper half has its own user lock bit. Every further register k has its own bit, k-1, in the second lock word. Lock bits can only be set and never cleared.

Commands enter on a valid/ready channel. A command is taken on any rising edge where `cmd_valid` and `cmd_ready` are both high. The sender holds op, offset and data stable until then. Read results leave on a second valid/ready channel. That channel holds a single entry. While a result waits with `rsp_ready` low, no new command is taken. A result that leaves in the same cycle that a new command is taken is allowed, so reads can run back to back.

A program or lock-program command marks the bank busy for a fixed number of cycles. Rejected commands, and why they were rejected, show in sticky status bits. A clear-status command resets those bits.

Top module: `otp_prot_bank`

## Requirements
- R1: After reset, every data word reads 0xFFFF, offset 136 reads 0x0001, offset 137 reads 0x0000, `status` is 0x80 and `rsp_valid` is low.
- R2: Command op 0 (read) returns the addressed word on `rsp_data` with `rsp_valid` high from the cycle after acceptance. The word offset map is:
  - data register k occupies words 8k to 8k+7, for k = 0 to 16;
  - offset 136 returns lock word 0 in bits [1:0], with upper bits zero;
  - offset 137 returns lock word 1;
  - any offset of 138 or above returns 0x0000.
  A read changes neither storage nor status.
- R3: Command op 1 (program word) is applied only when all of these hold: `pgm_en` is high, the offset is 0 to 135 and the segment is unlocked. The addressed word then becomes old AND `cmd_data`, and every other word is unchanged.
- R4: With `pgm_en` high, a command is out of range in either of these cases, and then it sets status bit 4 and alters nothing:
  - op 1 with offset 136 or above;
  - op 2 with an offset other than 136 or 137.
- R5: Words 0 to 3 (register 0 bits [63:0]) are locked from reset. Lock word 0 bit 0 always reads 1. An op 1 to a locked word sets status bits 5 and 4 and leaves the word unchanged.
- R6: Command op 2 (program lock word) to offset 136 sets lock word 0 bit 1 when `cmd_data[1]` is 1. Once set, that bit locks words 4 to 7. The other data bits have no effect, and bit 0 stays 1.
- R7: Op 2 to offset 137 ORs `cmd_data` into lock word 1. Bit n locks words 8(n+1) to 8(n+1)+7, so bit 5 locks register 6. Lock bits are never cleared.
- R8: When `pgm_en` is low, op 1 and op 2 set status bits 3 and 4 and change nothing. This check comes before the range check and the lock check.
- R9: Each accepted op 1 or op 2, whether applied or rejected, drives status bit 7 and `cmd_ready` low for exactly BUSY_CYCLES cycles. The low period starts in the cycle after acceptance.
- R10: Status bits 5, 4 and 3 stay set until an accepted op 3 (clear status) clears all three. Op 3 changes neither bit 7 nor storage. Status bits 6 and 2 to 0 read 0.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold and `cmd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pgm_en | input | 1 | Program-enable level; low blocks all alteration |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 read, 1 program word, 2 program lock word, 3 clear status |
| cmd_addr | input | 8 | Word offset |
| cmd_data | input | 16 | Program or lock data |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the read result |
| rsp_data | output | 16 | Read result |
| status | output | 8 | Bit 7 ready, bit 5 lock error, bit 4 program error, bit 3 enable-low error |

## Verification
Two events can fall in the same cycle: a read result being drained and the next command being accepted. The bench provokes this by holding `cmd_valid` high across two reads while `rsp_ready` stays high. It then checks that each result appears exactly once, with the right data, in consecutive cycles. The opposite case holds `rsp_ready` low and checks that the result holds while `cmd_ready` stays low. Randomly mixed program, lock, clear and read commands, with random `pgm_en`, are judged against a bench model of the array, the locks and the sticky status bits.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_LOCK  = 2'd2,
    OP_CLEAR = 2'd3
  } otp_op_e;

  localparam int ST_READY  = 7;
  localparam int ST_LOCKED = 5;
  localparam int ST_FAIL   = 4;
  localparam int ST_NOPEN  = 3;
endpackage

// File: rtl/otp_busy_timer.sv
module otp_busy_timer #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/otp_word_store.sv
module otp_word_store #(
  parameter int NUM_REGS  = 17,
  parameter int WPR       = 8,
  parameter int WORD_BITS = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_BITS-1:0] wdata,
  output logic [WORD_BITS-1:0] rdata
);
  localparam int WSEL_W = $clog2(WPR);
  localparam int RIDX_W = ADDR_W - WSEL_W;

  logic [RIDX_W-1:0] ridx;
  logic [WSEL_W-1:0] wsel;
  logic [NUM_REGS-1:0][WPR-1:0][WORD_BITS-1:0] all_q;

  assign ridx = addr[ADDR_W-1:WSEL_W];
  assign wsel = addr[WSEL_W-1:0];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [WPR-1:0][WORD_BITS-1:0] cells_q;
    logic hit;
    assign hit = we && (ridx == RIDX_W'(r));

    // Flash-style: erased cells are 1, programming only clears bits.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cells_q <= '1;
      else if (hit) cells_q[wsel] <= cells_q[wsel] & wdata;
    end

    assign all_q[r] = cells_q;
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      for (int w = 0; w < WPR; w++) begin
        if (ridx == RIDX_W'(r) && wsel == WSEL_W'(w)) rdata = all_q[r][w];
      end
    end
  end
endmodule

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl #(
  parameter int NUM_REGS  = 17,
  parameter int WPR       = 8,
  parameter int WORD_BITS = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_user,
  input  logic                 we_regs,
  input  logic [WORD_BITS-1:0] wdata,
  input  logic [ADDR_W-1:0]    addr,
  output logic [WORD_BITS-1:0] lock0_word,
  output logic [WORD_BITS-1:0] lock1_word,
  output logic                 seg_locked
);
  localparam int WSEL_W = $clog2(WPR);
  localparam int RIDX_W = ADDR_W - WSEL_W;
  localparam int NLK    = NUM_REGS - 1;

  logic             factory_lk;
  logic             user_lk_q;
  logic [NLK-1:0]   reg_lk_q;
  logic [RIDX_W-1:0] ridx;

  assign factory_lk = 1'b1;
  assign ridx       = addr[ADDR_W-1:WSEL_W];

  // Lock bits are set-only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_lk_q <= 1'b0;
      reg_lk_q  <= '0;
    end else begin
      if (we_user) user_lk_q <= user_lk_q | wdata[1];
      if (we_regs) reg_lk_q  <= reg_lk_q | wdata[NLK-1:0];
    end
  end

  always_comb begin
    seg_locked = 1'b0;
    if (ridx == '0) begin
      seg_locked = addr[WSEL_W-1] ? user_lk_q : factory_lk;
    end else begin
      for (int k = 0; k < NLK; k++) begin
        if (ridx == RIDX_W'(k + 1)) seg_locked = reg_lk_q[k];
      end
    end
  end

  always_comb begin
    lock0_word           = '0;
    lock0_word[0]        = factory_lk;
    lock0_word[1]        = user_lk_q;
    lock1_word           = '0;
    lock1_word[NLK-1:0]  = reg_lk_q;
  end
endmodule

// File: rtl/otp_prot_bank.sv
module otp_prot_bank
  import otp_pkg::*;
#(
  parameter int NUM_REGS    = 17,
  parameter int REG_BITS    = 128,
  parameter int WORD_BITS   = 16,
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pgm_en,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_op,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [WORD_BITS-1:0] cmd_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [WORD_BITS-1:0] rsp_data,
  output logic [7:0]           status
);
  localparam int WPR        = REG_BITS / WORD_BITS;
  localparam int DATA_WORDS = NUM_REGS * WPR;
  localparam int L0_ADDR    = DATA_WORDS;
  localparam int L1_ADDR    = DATA_WORDS + 1;

  otp_op_e op;
  logic accept, prog_like, busy_idle;
  logic in_data, at_l0, at_l1, range_ok, seg_locked;
  logic word_we, we_user, we_regs;
  logic [WORD_BITS-1:0] store_rd, lock0_word, lock1_word, rd_word;
  logic err_lock_q, err_fail_q, err_nopen_q;

  assign op        = otp_op_e'(cmd_op);
  assign accept    = cmd_valid && cmd_ready;
  assign prog_like = accept && (op == OP_PROG || op == OP_LOCK);
  assign in_data   = (cmd_addr < ADDR_W'(DATA_WORDS));
  assign at_l0     = (cmd_addr == ADDR_W'(L0_ADDR));
  assign at_l1     = (cmd_addr == ADDR_W'(L1_ADDR));
  assign range_ok  = (op == OP_PROG) ? in_data : (at_l0 || at_l1);

  assign word_we = prog_like && (op == OP_PROG) && pgm_en && in_data && !seg_locked;
  assign we_user = prog_like && (op == OP_LOCK) && pgm_en && at_l0;
  assign we_regs = prog_like && (op == OP_LOCK) && pgm_en && at_l1;

  otp_word_store #(
    .NUM_REGS(NUM_REGS), .WPR(WPR), .WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .we(word_we), .addr(cmd_addr),
    .wdata(cmd_data), .rdata(store_rd)
  );

  otp_lock_ctrl #(
    .NUM_REGS(NUM_REGS), .WPR(WPR), .WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W)
  ) lock_i (
    .clk(clk), .rst_n(rst_n), .we_user(we_user), .we_regs(we_regs),
    .wdata(cmd_data), .addr(cmd_addr), .lock0_word(lock0_word),
    .lock1_word(lock1_word), .seg_locked(seg_locked)
  );

  otp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) busy_i (
    .clk(clk), .rst_n(rst_n), .start(prog_like), .idle(busy_idle)
  );

  // Enable level is judged first, then range, then lock state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_lock_q  <= 1'b0;
      err_fail_q  <= 1'b0;
      err_nopen_q <= 1'b0;
    end else if (accept && op == OP_CLEAR) begin
      err_lock_q  <= 1'b0;
      err_fail_q  <= 1'b0;
      err_nopen_q <= 1'b0;
    end else if (prog_like) begin
      if (!pgm_en) begin
        err_nopen_q <= 1'b1;
        err_fail_q  <= 1'b1;
      end else if (!range_ok) begin
        err_fail_q  <= 1'b1;
      end else if (op == OP_PROG && seg_locked) begin
        err_lock_q  <= 1'b1;
        err_fail_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    if (in_data)    rd_word = store_rd;
    else if (at_l0) rd_word = lock0_word;
    else if (at_l1) rd_word = lock1_word;
    else            rd_word = '0;
  end

  // One-entry result stage; a drain and a new accept may share a cycle.
  assign cmd_ready = busy_idle && (!rsp_valid || rsp_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && op == OP_READ) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_comb begin
    status            = '0;
    status[ST_READY]  = busy_idle;
    status[ST_LOCKED] = err_lock_q;
    status[ST_FAIL]   = err_fail_q;
    status[ST_NOPEN]  = err_nopen_q;
  end
endmodule

// File: rtl/otp_prot_bank_chk.sv
module otp_prot_bank_chk #(
  parameter int WORD_BITS   = 16,
  parameter int BUSY_CYCLES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pgm_en,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [1:0]           cmd_op,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [WORD_BITS-1:0] rsp_data,
  input logic [7:0]           status
);
  localparam int LW = $clog2(BUSY_CYCLES + 2);

  logic acc, prog_acc;
  logic [LW-1:0] low_cnt;

  assign acc      = cmd_valid && cmd_ready;
  assign prog_acc = acc && (cmd_op == 2'd1 || cmd_op == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_cnt <= '0;
    else if (!status[7]) low_cnt <= low_cnt + 1'b1;
    else                 low_cnt <= '0;
  end

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_acc |=> !status[7] && !cmd_ready);

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> low_cnt == LW'(BUSY_CYCLES));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> status[7]);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));

  p_rsp_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd3) |=> status[5:3] == 3'b000);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !(acc && cmd_op == 2'd3)) |=> status[4]);

  p_pen_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_acc && !pgm_en) |=> status[3] && status[4]);
endmodule

bind otp_prot_bank otp_prot_bank_chk #(
  .WORD_BITS(WORD_BITS), .BUSY_CYCLES(BUSY_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .status(status)
);

// File: tb/otp_prot_bank_tb_top.sv
`timescale 1ns/1ps
module otp_prot_bank_tb_top;
  localparam int BUSY = 4;
  localparam int NW   = 136;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pgm_en = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_addr = 8'd0;
  logic [15:0] cmd_data = 16'd0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [7:0] status;

  always #10 clk = ~clk;

  otp_prot_bank #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .status(status)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] m_data [NW];
  logic m_user = 1'b0;
  logic [15:0] m_regs = 16'h0;
  logic e5 = 1'b0, e4 = 1'b0, e3 = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_locked(input int a);
    int r;
    r = a / 8;
    if (r == 0) return ((a % 8) < 4) ? 1'b1 : m_user;
    return m_regs[r-1];
  endfunction

  function automatic logic [15:0] exp_read(input int a);
    if (a < NW) return m_data[a];
    if (a == 136) return {14'd0, m_user, 1'b1};
    if (a == 137) return m_regs;
    return 16'h0000;
  endfunction

  task automatic model(input int op, input int a, input logic [15:0] d, input logic pen);
    if (op == 3) begin e5 = 0; e4 = 0; e3 = 0; end
    else if (op == 1) begin
      if (!pen) begin e3 = 1; e4 = 1; end
      else if (a >= NW) e4 = 1;
      else if (m_locked(a)) begin e5 = 1; e4 = 1; end
      else m_data[a] = m_data[a] & d;
    end else if (op == 2) begin
      if (!pen) begin e3 = 1; e4 = 1; end
      else if (a == 136) m_user = m_user | d[1];
      else if (a == 137) m_regs = m_regs | d;
      else e4 = 1;
    end
  endtask

  // Issue one command, check status, busy window and any read result.
  task automatic issue(input int op, input int a, input logic [15:0] d, input logic pen, input string req);
    logic [15:0] er;
    logic [7:0] es;
    int n;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    er = exp_read(a);
    pgm_en = pen; cmd_op = 2'(op); cmd_addr = 8'(a); cmd_data = d; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    model(op, a, d, pen);
    es = {(op == 1 || op == 2) ? 1'b0 : 1'b1, 1'b0, e5, e4, e3, 3'b000};
    chk(status == es, {req, " status after command (R10)"}, 32'(status), 32'(es));
    if (op == 0) begin
      chk(rsp_valid && rsp_data == er, {req, " read data (R2)"}, {15'd0, rsp_valid, rsp_data}, {16'h1, er});
    end
    if (op == 1 || op == 2) begin
      n = 0;
      while (!status[7] && n < 50) begin n++; @(negedge clk); end
      chk(n == BUSY, "R9 busy window length", 32'(n), 32'(BUSY));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) m_data[i] = 16'hFFFF;
    void'($urandom(32'h0051_7A3E));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(status == 8'h80, "R1 reset status", 32'(status), 32'h80);
    chk(!rsp_valid, "R1 reset rsp_valid", 32'(rsp_valid), 0);
    issue(0, 0, 0, 1, "R1 word 0");
    issue(0, 135, 0, 1, "R1 word 135");
    issue(0, 136, 0, 1, "R1 lock word 0");
    issue(0, 137, 0, 1, "R1 lock word 1");
    issue(0, 200, 0, 1, "R2 out-of-range read");

    // R3 AND programming
    issue(1, 20, 16'hF0F0, 1, "R3 program");
    issue(1, 20, 16'hFF0F, 1, "R3 program again");
    issue(0, 20, 0, 1, "R3 readback");
    chk(rsp_data == 16'hF000, "R3 AND result", 32'(rsp_data), 32'hF000);
    issue(0, 21, 0, 1, "R3 neighbour untouched");

    // R5 factory segment
    issue(1, 2, 16'h0000, 1, "R5 factory program");
    chk(status[5:4] == 2'b11, "R5 lock error bits", 32'(status), 32'h30);
    issue(0, 2, 0, 1, "R5 factory readback");
    issue(3, 0, 0, 1, "R10 clear");
    issue(1, 4, 16'h00FF, 1, "R6 user half before lock");

    // R6 user lock
    issue(2, 136, 16'hFFFC, 1, "R6 lock other bits only");
    issue(0, 136, 0, 1, "R6 lock word 0 unchanged");
    issue(2, 136, 16'h0002, 1, "R6 set user lock");
    issue(1, 5, 16'h0000, 1, "R6 user half locked");
    issue(0, 5, 0, 1, "R6 readback");
    issue(0, 136, 0, 1, "R6 lock word 0 value");
    issue(3, 0, 0, 1, "R10 clear");

    // R7 register lock: bit 5 locks register 6 (words 48..55)
    issue(2, 137, 16'h0020, 1, "R7 lock reg 6");
    issue(1, 48, 16'h0000, 1, "R7 reg 6 first word");
    issue(1, 55, 16'h0000, 1, "R7 reg 6 last word");
    issue(3, 0, 0, 1, "R10 clear");
    issue(1, 56, 16'h1234, 1, "R7 reg 7 still open");
    issue(1, 47, 16'h4321, 1, "R7 reg 5 still open");
    issue(2, 137, 16'h0000, 1, "R7 bits never clear");
    issue(0, 137, 0, 1, "R7 lock word 1 value");

    // R8 enable low, R4 range
    issue(1, 60, 16'h0000, 0, "R8 program enable low");
    issue(0, 60, 0, 1, "R8 word kept");
    issue(2, 137, 16'hFFFF, 0, "R8 lock enable low");
    issue(0, 137, 0, 1, "R8 locks kept");
    issue(3, 0, 0, 1, "R10 clear");
    issue(1, 136, 16'h0000, 0, "R8 priority over range");
    issue(3, 0, 0, 1, "R10 clear");
    issue(1, 136, 16'h0000, 1, "R4 program at 136");
    issue(0, 136, 0, 1, "R4 lock word 0 intact");
    issue(3, 0, 0, 1, "R10 clear");
    issue(2, 50, 16'hFFFF, 1, "R4 lock op bad offset");
    issue(0, 50, 0, 1, "R4 word intact");
    issue(1, 250, 16'h0000, 1, "R4 far offset");
    issue(3, 0, 0, 1, "R10 clear");

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    issue(0, 20, 0, 1, "R11 stalled read");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == 16'hF000, "R11 result held", 32'(rsp_data), 32'hF000);
      chk(!cmd_ready, "R11 cmd_ready low while stalled", 32'(cmd_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && cmd_ready, "R11 drained", {30'd0, rsp_valid, cmd_ready}, 32'h1);

    // Drain and accept in the same cycle (R2, R11)
    cmd_op = 2'd0; cmd_addr = 8'd20; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_data == exp_read(20), "R2 back-to-back first", 32'(rsp_data), 32'(exp_read(20)));
    chk(cmd_ready, "R11 ready while draining", 32'(cmd_ready), 1);
    cmd_addr = 8'd56;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rsp_valid && rsp_data == exp_read(56), "R2 back-to-back second", 32'(rsp_data), 32'(exp_read(56)));
    @(negedge clk);
    chk(!rsp_valid, "R11 single result per read", 32'(rsp_valid), 0);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      int op, a, sel;
      logic [15:0] d;
      logic pen;
      sel = int'($urandom_range(0, 99));
      if (sel < 35) op = 0;
      else if (sel < 75) op = 1;
      else if (sel < 82) op = 2;
      else op = 3;
      a = int'($urandom_range(0, 143));
      if (op == 2 && $urandom_range(0, 3) != 0) a = 136 + int'($urandom_range(0, 1));
      d = 16'($urandom) | 16'($urandom);
      if (op == 2) d = 16'(1 << $urandom_range(0, 15));
      pen = ($urandom_range(0, 9) != 0);
      issue(op, a, d, pen, "R3 random");
    end

    // Final sweep of storage against model
    for (int a = 0; a < 140; a++) issue(0, a, 0, 1, "R2 final sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule